// File: doc/BRIEF.md
# Multi-mode page translator

This block maps a 4 MB virtual window, starting at 0x3F80_0000, onto external RAM in 32 KB pages. A mapping table of 9-bit entries is filled through a plain write port. Each entry is addressed by a 12-bit index in the range 0 to 4095. A lookup supplies the requesting core (0 or 1), a 3-bit process ID, a 32-bit virtual address and a 2-bit mode. One registered cycle later the block returns either a 23-bit physical address or a fault.

Every process ID owns a 128-entry block in a lower table set and another in an upper table set. IDs 0 and 1 share the same blocks. The mode decides which set serves an access:

- **Normal** (code 0): chosen by the requesting core.
- **Low-High** (code 1): chosen by the upper or lower half of the window.
- **Even-Odd** (code 2): chosen by alternating 32-byte chunks of the address.
- Code 3 is reserved.

Lookups use a valid/ready handshake and so do results. A result is held unchanged while `res_ready` is low. A new lookup is accepted only when the result register is empty or is being drained in the same cycle.

Top module: `page_xlate`

## Requirements
- R1: After reset, `res_valid` is 0, `lk_ready` is 1, and every table entry reads as invalid (value 0x100), so any in-window lookup faults until that entry is written.
- R2: A lookup whose `lk_vaddr[31:22]` differs from 0x0FE, which places it outside 0x3F80_0000 to 0x3FBF_FFFF, returns fault without using the table.
- R3: A lookup that hits a valid entry returns `res_fault`=0 and `res_paddr` = {entry[7:0], lk_vaddr[14:0]}.
- R4: The page number is `lk_vaddr[21:15]`. The lower-set entry index is 1152 + 128*(max(pid,1)-1) + page, so IDs 0 and 1 share the block that starts at 1152.
- R5: The upper-set entry index is 3200 + 128*(max(pid,1)-1) + page, so PID 7 with page 0x4E uses entry 4046.
- R6: In Normal mode (`lk_mode`=0), core 0 uses the lower set and core 1 uses the upper set.
- R7: In Low-High mode (`lk_mode`=1), pages 64 to 127 use the upper set and pages 0 to 63 use the lower set, whichever core asks.
- R8: In Even-Odd mode (`lk_mode`=2), `lk_vaddr[5]`=0 selects the lower set and 1 selects the upper set, whichever core asks.
- R9: An entry with bit 8 set is invalid. A lookup that hits it returns `res_fault`=1, and `res_paddr` is then driven to 0.
- R10: A table write and a lookup of the same entry on the same clock edge return the entry's previous value. The new value applies from the next lookup onward.
- R11: A lookup transfers on an edge where `lk_valid` and `lk_ready` are both high. `lk_ready` equals (not `res_valid`) or `res_ready`. While `res_valid` is high and `res_ready` is low, the result stays stable.
- R12: A lookup with `lk_mode`=3 returns fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-assert, active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 12 | Table entry index for the write |
| wr_data | input | 9 | Entry value: [7:0] physical page, [8] invalid flag |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_cpu | input | 1 | Requesting core, 0 or 1 |
| lk_pid | input | 3 | Process ID |
| lk_vaddr | input | 32 | Virtual address |
| lk_mode | input | 2 | 0 Normal, 1 Low-High, 2 Even-Odd, 3 reserved |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumer ready |
| res_fault | output | 1 | Lookup faulted |
| res_paddr | output | 23 | Physical address, 0 on fault |

## Verification
A lookup accepted on one rising edge has its result visible right after that edge. The bench drives inputs 2 ns after a rising edge and samples at the falling edge, so each result is compared half a period after the edge that produced it. A table write becomes visible to any lookup accepted on a later edge. The same-edge case is checked against the old value. Under back-pressure, the scoreboard pops a result only at a falling edge where both `res_valid` and `res_ready` are high, and the stalled result and `lk_ready` are checked on every falling edge of the stall.

// File: rtl/xl_pkg.sv
package xl_pkg;
  localparam int VA_W      = 32;
  localparam int OFS_W     = 15;              // 32 KB page offset
  localparam int PG_W      = 7;               // 128 pages in the window
  localparam int PAGES     = 1 << PG_W;
  localparam int WIN_LSB   = OFS_W + PG_W;
  localparam int WIN_W     = VA_W - WIN_LSB;
  localparam logic [WIN_W-1:0] WIN_TAG = WIN_W'(10'h0FE);
  localparam int PPN_W     = 8;
  localparam int ENT_W     = PPN_W + 1;
  localparam int IDX_W     = 12;
  localparam int PID_W     = 3;
  localparam int BLOCKS    = (1 << PID_W) - 1; // ids 0 and 1 share a block
  localparam int LO_BASE   = 1152;
  localparam int HI_BASE   = 3200;
  localparam int CHUNK_BIT = 5;               // 32-byte interleave
  localparam int PA_W      = PPN_W + OFS_W;

  typedef enum logic [1:0] {
    XM_BY_CORE  = 2'd0,
    XM_BY_HALF  = 2'd1,
    XM_BY_CHUNK = 2'd2,
    XM_RSVD     = 2'd3
  } xl_mode_e;
endpackage

// File: rtl/xl_route.sv
module xl_route
  import xl_pkg::*;
#(
  localparam int DEPTH = BLOCKS * PAGES,
  localparam int OFF_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu,
  input  logic [PID_W-1:0] pid,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [1:0]       mode,
  output logic             in_win,
  output logic             mode_ok,
  output logic             use_hi,
  output logic [OFF_W-1:0] off
);
  xl_mode_e         m;
  logic [PG_W-1:0]  page;
  logic [PID_W-1:0] blk;

  always_comb begin
    m       = xl_mode_e'(mode);
    in_win  = (vaddr[VA_W-1:WIN_LSB] == WIN_TAG);
    page    = vaddr[WIN_LSB-1:OFS_W];
    blk     = (pid < PID_W'(2)) ? '0 : pid - PID_W'(1);
    off     = OFF_W'(int'(blk) * PAGES + int'(page));
    mode_ok = (m != XM_RSVD);
    unique case (m)
      XM_BY_CORE:  use_hi = cpu;
      XM_BY_HALF:  use_hi = page[PG_W-1];
      XM_BY_CHUNK: use_hi = vaddr[CHUNK_BIT];
      default:     use_hi = 1'b0;
    endcase
  end

  // R4: the block offset never leaves the stored range
  p_off_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(off) < DEPTH);
endmodule

// File: rtl/xl_bank.sv
module xl_bank
  import xl_pkg::*;
#(
  parameter int BASE = LO_BASE,
  localparam int DEPTH = BLOCKS * PAGES,
  localparam int OFF_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_data,
  input  logic [OFF_W-1:0] rd_off,
  output logic [ENT_W-1:0] rd_data
);
  localparam logic [ENT_W-1:0] EMPTY = ENT_W'(1) << PPN_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic             wr_hit;
  logic [OFF_W-1:0] wr_off;

  always_comb begin
    wr_hit  = wr_en && (int'(wr_idx) >= BASE) && (int'(wr_idx) < BASE + DEPTH);
    wr_off  = OFF_W'(wr_idx - IDX_W'(BASE));
    rd_data = mem[rd_off];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= EMPTY;
    end else if (wr_hit) begin
      mem[wr_off] <= wr_data;
    end
  end
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import xl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [11:0] wr_idx,
  input  logic [8:0]  wr_data,
  input  logic        lk_valid,
  output logic        lk_ready,
  input  logic        lk_cpu,
  input  logic [2:0]  lk_pid,
  input  logic [31:0] lk_vaddr,
  input  logic [1:0]  lk_mode,
  output logic        res_valid,
  input  logic        res_ready,
  output logic        res_fault,
  output logic [22:0] res_paddr
);
  localparam int DEPTH = BLOCKS * PAGES;
  localparam int OFF_W = $clog2(DEPTH);
  localparam int NSETS = 2;

  logic             in_win, mode_ok, use_hi, accept, hit;
  logic [OFF_W-1:0] off;
  logic [ENT_W-1:0] ent [NSETS];
  logic [ENT_W-1:0] sel;

  xl_route u_route (
    .clk    (clk),
    .rst_n  (rst_n),
    .cpu    (lk_cpu),
    .pid    (lk_pid),
    .vaddr  (lk_vaddr),
    .mode   (lk_mode),
    .in_win (in_win),
    .mode_ok(mode_ok),
    .use_hi (use_hi),
    .off    (off)
  );

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    xl_bank #(.BASE(g == 0 ? LO_BASE : HI_BASE)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_data(wr_data),
      .rd_off (off),
      .rd_data(ent[g])
    );
  end

  always_comb begin
    lk_ready = !res_valid || res_ready;
    accept   = lk_valid && lk_ready;
    sel      = ent[use_hi];
    hit      = in_win && mode_ok && !sel[ENT_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_fault <= 1'b0;
      res_paddr <= '0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_fault <= !hit;
      res_paddr <= hit ? {sel[PPN_W-1:0], lk_vaddr[OFS_W-1:0]} : '0;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R11: a stalled result holds still
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_fault) && $stable(res_paddr));
  // R11: an accepted lookup always yields a result
  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> res_valid);
  // R2: addresses outside the window fault
  p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready && (lk_vaddr[31:22] != 10'h0FE) |=> res_fault);
  // R12: reserved mode faults
  p_mode_rsvd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready && (lk_mode == 2'd3) |=> res_fault);
  // R9: a faulted result carries a zero address
  p_fault_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault |-> res_paddr == '0);
endmodule

// File: tb/page_xlate_bench.sv
module page_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_idx = '0;
  logic [8:0]  wr_data = '0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic        lk_cpu = 1'b0;
  logic [2:0]  lk_pid = '0;
  logic [31:0] lk_vaddr = '0;
  logic [1:0]  lk_mode = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_fault;
  logic [22:0] res_paddr;

  int n_checks = 0;
  int n_fail = 0;
  logic [8:0]  mdl [4096];
  logic [23:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk; // 125 MHz

  page_xlate u_page_xlate (.*);

  task automatic check(bit ok, string tag, logic [23:0] act, logic [23:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [23:0] expect_of(logic cpu, logic [2:0] pid,
                                            logic [31:0] va, logic [1:0] mode);
    int page, base;
    bit hi;
    logic [8:0] e;
    if (va[31:22] != 10'h0FE || mode == 2'd3) return 24'h800000;
    page = int'(va[21:15]);
    case (mode)
      2'd0:    hi = cpu;
      2'd1:    hi = page >= 64;
      default: hi = va[5];
    endcase
    base = (hi ? 3200 : 1152) + 128 * ((pid < 2) ? 0 : int'(pid) - 1);
    e = mdl[base + page];
    if (e[8]) return 24'h800000;
    return {1'b0, e[7:0], va[14:0]};
  endfunction

  task automatic do_write(int idx, logic [8:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_idx = 12'(idx); wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
    mdl[idx] = d;
  endtask

  task automatic do_lookup(logic cpu, logic [2:0] pid, logic [31:0] va,
                           logic [1:0] mode, string tag,
                           bit wr = 1'b0, int widx = 0, logic [8:0] wd = '0);
    logic [23:0] e;
    @(posedge clk); #2;
    lk_cpu = cpu; lk_pid = pid; lk_vaddr = va; lk_mode = mode; lk_valid = 1'b1;
    if (wr) begin wr_en = 1'b1; wr_idx = 12'(widx); wr_data = wd; end
    e = expect_of(cpu, pid, va, mode);
    do @(negedge clk); while (!lk_ready);
    @(posedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (wr) mdl[widx] = wd;
    #2;
    lk_valid = 1'b0;
    wr_en = 1'b0;
  endtask

  // monitor: pops the scoreboard when a result transfers
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && res_valid && res_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11 unexpected result", {res_fault, res_paddr}, 24'h0);
        end else begin
          logic [23:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({res_fault, res_paddr} === e, t, {res_fault, res_paddr}, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [23:0] held;
    for (int i = 0; i < 4096; i++) mdl[i] = 9'h100;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(res_valid == 1'b0, "R1 res_valid after reset", {23'h0, res_valid}, 24'h0);
    check(lk_ready == 1'b1, "R1 lk_ready after reset", {23'h0, lk_ready}, 24'h1);
    do_lookup(1'b0, 3'd3, 32'h3F80_0000, 2'd0, "R1 empty entry faults");
    do_lookup(1'b1, 3'd7, 32'h3FBF_FFFF, 2'd1, "R1 empty upper entry faults");

    // R5 R7 R3: pid 7, page 0x4E, upper half
    do_write(4046, 9'h0FF);
    do_lookup(1'b0, 3'd7, 32'h3FA7_2375, 2'd1, "R5 R7 R3 core0 upper half");
    do_lookup(1'b1, 3'd7, 32'h3FA7_2375, 2'd1, "R7 core1 same mapping");
    do_write(1920 + 5, 9'h011);
    do_lookup(1'b1, 3'd7, 32'h3F82_8010, 2'd1, "R7 lower half page 5");

    // R8 R4: interleaved chunks, pid 5 page 0x0A
    do_write(1674, 9'h0AA);
    do_write(3722, 9'h0AB);
    do_lookup(1'b1, 3'd5, 32'h3F85_5805, 2'd2, "R8 chunk bit 0 lower");
    do_lookup(1'b1, 3'd5, 32'h3F85_5823, 2'd2, "R8 chunk bit 1 upper");
    do_lookup(1'b0, 3'd5, 32'h3F85_5823, 2'd2, "R8 core0 same mapping");

    // R6 R4: per-core sets, pids 0 and 1 share
    do_write(1152, 9'h020);
    do_write(3200, 9'h040);
    do_lookup(1'b0, 3'd1, 32'h3F80_0876, 2'd0, "R6 core0 lower set");
    do_lookup(1'b1, 3'd1, 32'h3F80_0876, 2'd0, "R6 core1 upper set");
    do_lookup(1'b0, 3'd0, 32'h3F80_0876, 2'd0, "R4 pid0 shares pid1 block");

    // R4 R5: block starts for pids 2..7 at page 127
    for (int p = 2; p < 8; p++) begin
      do_write(1152 + 128 * (p - 1) + 127, 9'(p));
      do_write(3200 + 128 * (p - 1) + 127, 9'(p + 16));
    end
    for (int p = 2; p < 8; p++) begin
      do_lookup(1'b0, 3'(p), 32'h3FBF_8ABC, 2'd0, "R4 lower block start");
      do_lookup(1'b1, 3'(p), 32'h3FBF_8ABC, 2'd0, "R5 upper block start");
    end

    // R2: outside the window
    do_lookup(1'b0, 3'd1, 32'h3FC0_0876, 2'd0, "R2 above window");
    do_lookup(1'b0, 3'd1, 32'h3F7F_FFFF, 2'd0, "R2 below window");

    // R9: invalid flag
    do_write(4046, 9'h1FF);
    do_lookup(1'b0, 3'd7, 32'h3FA7_2375, 2'd1, "R9 invalid entry faults");

    // R12: reserved mode
    do_lookup(1'b0, 3'd1, 32'h3F80_0876, 2'd3, "R12 reserved mode faults");

    // R10: same-edge write returns old value, then new
    do_lookup(1'b0, 3'd1, 32'h3F80_0876, 2'd0, "R10 old value on same edge",
              1'b1, 1152, 9'h033);
    do_lookup(1'b0, 3'd1, 32'h3F80_0876, 2'd0, "R10 new value next lookup");

    // R11: back-pressure
    @(posedge clk); #2 res_ready = 1'b0;
    do_lookup(1'b1, 3'd1, 32'h3F80_0876, 2'd0, "R11 stalled result");
    fork
      do_lookup(1'b1, 3'd5, 32'h3F85_5823, 2'd2, "R11 lookup after stall");
      begin
        @(negedge clk);
        held = {res_fault, res_paddr};
        for (int k = 0; k < 4; k++) begin
          check(lk_ready == 1'b0, "R11 lk_ready low while stalled",
                {23'h0, lk_ready}, 24'h0);
          check(res_valid && ({res_fault, res_paddr} == held), "R11 result held",
                {res_fault, res_paddr}, held);
          @(negedge clk);
        end
        @(posedge clk); #2 res_ready = 1'b1;
      end
    join
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R11 all results delivered", 24'(exp_q.size()), 24'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule